// File: doc/BRIEF.md
# Manual Word Boundary Aligner

This block sits after a deserializer and finds the word boundary in a parallel receive stream that is 8, 10, 16 or 20 bits wide. It keeps the last two received words as one history of twice the word width. Each cycle it compares a programmed alignment pattern against every bit offset of that history. It then sends out the word taken at the chosen boundary, together with a pattern-found pulse and a boundary-locked pulse. All three outputs leave on the same cycle.

A user control input, `pattern_align`, decides whether the aligner may adopt a new boundary. At 10-bit width the control works on its level. Searching continues for as long as it is high, and the aligner can re-lock to a new offset at any time. At the other widths a rising edge arms a single search, and that search ends at the first pattern found. When no search is active, the boundary stays where it is, and a pattern seen at that boundary only raises the pattern-found pulse.

The controller is a three-state machine:
- `WA_HOLD` keeps the boundary fixed. It moves to `WA_SEEK` (or locks at once) when searching becomes active: a rising edge at 8, 16 or 20 bits, or a high level at 10 bits.
- `WA_SEEK` waits for the first pattern. At 8, 16 or 20 bits it returns to `WA_HOLD` on that pattern. At 10 bits it goes to `WA_TRACK` on that pattern, and back to `WA_HOLD` when the control falls.
- `WA_TRACK` is used only at 10 bits. It follows the pattern to new offsets while the control stays high, and returns to `WA_HOLD` when the control falls.

Top module: `wordalign_manual`

## Requirements
- R1: Bits are taken in serial order, least significant bit first, and the older word comes first. The output word at offset k holds bits k..W-1 of the older word in its low positions, followed by bits 0..k-1 of the newer word. An input word appears at the output two clock edges after the edge that captures it.
- R2: At W = 10, searching is active on every cycle in which `pattern_align` is high. When it is low, no boundary change and no `sync_pulse` happen.
- R3: At W = 8, 16 or 20, a rising edge of `pattern_align` arms the search. The search stays armed until the first pattern is found, whatever the control level does meanwhile. A pattern present in the same cycle as the edge counts as found. Once the search ends, a pattern at another offset is ignored until the next rising edge.
- R4: The first pattern found by an active search moves the boundary to its offset. It raises both `pat_det` and `sync_pulse` for exactly one cycle.
- R5: A pattern at the current boundary, outside a first search, raises only `pat_det` for one cycle.
- R6: At W = 10, after locking with `pattern_align` still high, a pattern at a different offset moves the boundary there and raises `pat_det` and `sync_pulse` for one cycle. Later words use the new offset.
- R7: When searching is not active, a pattern at an offset other than the current boundary leaves the boundary unchanged and raises no pulse.
- R8: When several offsets match in one cycle, a first search takes the lowest offset. Outside a first search, a match at the current boundary takes precedence over any other offset.
- R9: `pat_det` and `sync_pulse` share the latency of the data path, so the word output alongside a pulse equals the pattern.
- R10: Synchronous reset sets the boundary to offset 0, clears the history, and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word | input | W | Parallel word from the deserializer |
| pattern_align | input | 1 | Search control: level at W = 10, rising edge otherwise |
| word_out | output | W | Word at the current boundary |
| pat_det | output | 1 | One-cycle pulse: pattern seen at the boundary in use |
| sync_pulse | output | 1 | One-cycle pulse: boundary newly adopted |

## Verification
Two instances are driven: a 10-bit one with the control level-sensitive, and an 8-bit one with the control edge-armed. Zero-filled stretches carrying one pattern at a chosen offset separate three cases: a real move, a pattern repeated at the held boundary, and a pattern ignored because no search is active. Random filler words show that the data path keeps the chosen offset. A run of alternating bits in the 8-bit instance matches at several even offsets at once, which tells lowest-offset selection apart from preference for the current boundary. Toggling the control shows the 10-bit instance re-locking while the level is high, and the 8-bit instance accepting only one pattern per rising edge.

// File: rtl/wa_pkg.sv
package wa_pkg;

    typedef enum logic [1:0] {
        WA_HOLD  = 2'd0,
        WA_SEEK  = 2'd1,
        WA_TRACK = 2'd2
    } wa_state_e;

endpackage

// File: rtl/wa_history.sv
module wa_history #(
    parameter int W = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   din,
    output logic [2*W-1:0] hist
);
    logic [W-1:0] newer_q;
    logic [W-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            newer_q <= '0;
            older_q <= '0;
        end else begin
            newer_q <= din;
            older_q <= newer_q;
        end
    end

    // Older word occupies the low half: serial order runs upward.
    assign hist = {newer_q, older_q};
endmodule

// File: rtl/wa_matcher.sv
module wa_matcher #(
    parameter int         W       = 10,
    parameter logic [W-1:0] PATTERN = '0,
    parameter int         OW      = 4
) (
    input  logic [2*W-1:0] hist,
    output logic [W-1:0]   hit,
    output logic           any_hit,
    output logic [OW-1:0]  low_off
);
    for (genvar k = 0; k < W; k++) begin : g_off
        assign hit[k] = (hist[k +: W] == PATTERN);
    end

    assign any_hit = |hit;

    always_comb begin
        low_off = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hit[k]) low_off = OW'(k);
        end
    end
endmodule

// File: rtl/wa_ctrl.sv
module wa_ctrl
    import wa_pkg::*;
#(
    parameter int W     = 10,
    parameter int OW    = 4,
    parameter bit LEVEL = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pattern_align,
    input  logic [W-1:0]  hit,
    input  logic          any_hit,
    input  logic [OW-1:0] low_off,
    output logic [OW-1:0] bnd_q,
    output logic [OW-1:0] bnd_n,
    output logic          det_n,
    output logic          sync_n
);
    wa_state_e state_q, state_n;
    logic      pa_q;
    logic      rise;
    logic      seek;
    logic      track;

    assign rise = pattern_align & ~pa_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WA_HOLD;
            bnd_q   <= '0;
            pa_q    <= 1'b0;
        end else begin
            state_q <= state_n;
            bnd_q   <= bnd_n;
            pa_q    <= pattern_align;
        end
    end

    always_comb begin
        state_n = state_q;
        bnd_n   = bnd_q;
        det_n   = 1'b0;
        sync_n  = 1'b0;
        seek    = 1'b0;
        track   = 1'b0;
        unique case (state_q)
            WA_HOLD:  seek  = LEVEL ? pattern_align : rise;
            WA_SEEK:  seek  = LEVEL ? pattern_align : 1'b1;
            WA_TRACK: track = pattern_align;
            default:  seek  = 1'b0;
        endcase
        if (seek) begin
            if (any_hit) begin
                bnd_n   = low_off;
                det_n   = 1'b1;
                sync_n  = 1'b1;
                state_n = LEVEL ? WA_TRACK : WA_HOLD;
            end else begin
                state_n = WA_SEEK;
            end
        end else if (track) begin
            if (hit[bnd_q]) begin
                det_n = 1'b1;
            end else if (any_hit) begin
                bnd_n  = low_off;
                det_n  = 1'b1;
                sync_n = 1'b1;
            end
        end else begin
            state_n = WA_HOLD;
            if (hit[bnd_q]) det_n = 1'b1;
        end
    end
endmodule

// File: rtl/wordalign_manual.sv
module wordalign_manual #(
    parameter int           W       = 10,
    parameter logic [W-1:0] PATTERN = 10'h17C
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rx_word,
    input  logic         pattern_align,
    output logic [W-1:0] word_out,
    output logic         pat_det,
    output logic         sync_pulse
);
    localparam int OW    = (W > 1) ? $clog2(W) : 1;
    localparam bit LEVEL = (W == 10);

    logic [2*W-1:0] hist;
    logic [W-1:0]   hit;
    logic           any_hit;
    logic [OW-1:0]  low_off;
    logic [OW-1:0]  bnd_q;
    logic [OW-1:0]  bnd_n;
    logic           det_n;
    logic           sync_n;

    wa_history #(.W(W)) u_hist (
        .clk (clk),
        .rst (rst),
        .din (rx_word),
        .hist(hist)
    );

    wa_matcher #(.W(W), .PATTERN(PATTERN), .OW(OW)) u_match (
        .hist   (hist),
        .hit    (hit),
        .any_hit(any_hit),
        .low_off(low_off)
    );

    wa_ctrl #(.W(W), .OW(OW), .LEVEL(LEVEL)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .pattern_align(pattern_align),
        .hit          (hit),
        .any_hit      (any_hit),
        .low_off      (low_off),
        .bnd_q        (bnd_q),
        .bnd_n        (bnd_n),
        .det_n        (det_n),
        .sync_n       (sync_n)
    );

    // Output stage: flags and the word leave together.
    always_ff @(posedge clk) begin
        if (rst) begin
            word_out   <= '0;
            pat_det    <= 1'b0;
            sync_pulse <= 1'b0;
        end else begin
            word_out   <= hist[bnd_n +: W];
            pat_det    <= det_n;
            sync_pulse <= sync_n;
        end
    end
endmodule

// File: rtl/wa_checker.sv
module wa_checker #(
    parameter int           W       = 10,
    parameter logic [W-1:0] PATTERN = '0,
    parameter int           OW      = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          pattern_align,
    input logic [W-1:0]  word_out,
    input logic          pat_det,
    input logic          sync_pulse,
    input logic [OW-1:0] bnd
);
    localparam bit LEVEL = (W == 10);

    p_sync_with_det_r4: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> pat_det);

    p_flag_word_r9: assert property (@(posedge clk) disable iff (rst)
        pat_det |-> (word_out == PATTERN));

    p_move_needs_sync_r7: assert property (@(posedge clk) disable iff (rst)
        (bnd != $past(bnd)) |-> sync_pulse);

    p_quiet_after_reset_r10: assert property (@(posedge clk)
        rst |=> (!pat_det && !sync_pulse && bnd == '0 && word_out == '0));

    if (LEVEL) begin : g_level
        p_level_low_no_sync_r2: assert property (@(posedge clk) disable iff (rst)
            !$past(pattern_align) |-> !sync_pulse);
    end
endmodule

bind wordalign_manual wa_checker #(.W(W), .PATTERN(PATTERN), .OW(OW)) u_wa_chk (
    .clk          (clk),
    .rst          (rst),
    .pattern_align(pattern_align),
    .word_out     (word_out),
    .pat_det      (pat_det),
    .sync_pulse   (sync_pulse),
    .bnd          (bnd_q)
);

// File: tb/test_wordalign_manual.sv
module test_wordalign_manual;
    localparam int          W0 = 10;
    localparam logic [9:0]  P0 = 10'h17C;
    localparam int          W1 = 8;
    localparam logic [7:0]  P1 = 8'h55;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [W0-1:0] din0 = '0;
    logic          pa0  = 1'b0;
    logic [W0-1:0] dout0;
    logic          det0, sync0;
    logic [W1-1:0] din1 = '0;
    logic          pa1  = 1'b0;
    logic [W1-1:0] dout1;
    logic          det1, sync1;

    wordalign_manual #(.W(W0), .PATTERN(P0)) i_wordalign_manual (
        .clk(clk), .rst(rst), .rx_word(din0), .pattern_align(pa0),
        .word_out(dout0), .pat_det(det0), .sync_pulse(sync0));

    wordalign_manual #(.W(W1), .PATTERN(P1)) i_wordalign_manual_n8 (
        .clk(clk), .rst(rst), .rx_word(din1), .pattern_align(pa1),
        .word_out(dout1), .pat_det(det1), .sync_pulse(sync1));

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [21:0] q0[$];
    logic [21:0] q1[$];
    string       t0q[$];
    string       t1q[$];
    string       tag0 = "R1";
    string       tag1 = "R1";

    // Reference state per lane (0: 10-bit level, 1: 8-bit edge)
    logic [19:0] mcur[2];
    logic [19:0] mprev[2];
    int          mst[2];
    int          mbnd[2];
    bit          mpaq[2];
    int          mw[2];
    bit          mlvl[2];
    logic [19:0] mpat[2];

    task automatic model(input int L, input logic [19:0] wn, input bit pa,
                         output logic [21:0] e);
        logic [39:0] h;
        logic [19:0] mask;
        int  low, use_off;
        bit  any, seek, track, at_bnd, d, s, rise;
        mask = 20'((40'd1 << mw[L]) - 40'd1);
        h = (40'(mcur[L]) << mw[L]) | 40'(mprev[L]);
        any = 0; low = 0;
        for (int k = mw[L] - 1; k >= 0; k--)
            if (((h >> k) & 40'(mask)) == 40'(mpat[L])) begin any = 1; low = k; end
        at_bnd = (((h >> mbnd[L]) & 40'(mask)) == 40'(mpat[L]));
        rise  = pa && !mpaq[L];
        seek  = mlvl[L] ? (pa && mst[L] != 2) : (mst[L] == 1 || rise);
        track = mlvl[L] && pa && mst[L] == 2;
        d = 0; s = 0;
        if (seek) begin
            if (any) begin
                mbnd[L] = low; d = 1; s = 1; mst[L] = mlvl[L] ? 2 : 0;
            end else mst[L] = 1;
        end else if (track) begin
            if (at_bnd) d = 1;
            else if (any) begin mbnd[L] = low; d = 1; s = 1; end
        end else begin
            mst[L] = 0;
            if (at_bnd) d = 1;
        end
        use_off = mbnd[L];
        e = {20'(h >> use_off) & mask, d, s};
        mpaq[L]  = pa;
        mprev[L] = mcur[L];
        mcur[L]  = wn & mask;
    endtask

    // Driver: one word per lane per cycle, expected items queued.
    task automatic step(input logic [19:0] w0, input bit p0,
                        input logic [19:0] w1, input bit p1);
        logic [21:0] e;
        @(negedge clk);
        rst  = 1'b0;
        din0 = w0[W0-1:0]; pa0 = p0;
        din1 = w1[W1-1:0]; pa1 = p1;
        model(0, w0, p0, e); q0.push_back(e); t0q.push_back(tag0);
        model(1, w1, p1, e); q1.push_back(e); t1q.push_back(tag1);
    endtask

    bit hold0 = 1'b0;
    bit hold1 = 1'b0;
    task automatic s0(input logic [19:0] w); step(w, hold0, 20'd0, hold1); endtask
    task automatic s1(input logic [19:0] w); step(20'd0, hold0, w, hold1); endtask

    task automatic pat0(input int k);
        s0(20'((40'(P0) << k) & 40'h3FF));
        s0(20'(40'(P0) >> (W0 - k)));
    endtask
    task automatic pat1(input int k);
        s1(20'((40'(P1) << k) & 40'hFF));
        s1(20'(40'(P1) >> (W1 - k)));
    endtask

    // Monitor: pops and compares as results appear.
    initial begin
        logic [21:0] e, a;
        string t;
        forever begin
            @(posedge clk);
            #1;
            if (q0.size() > 0) begin
                e = q0.pop_front(); t = t0q.pop_front();
                a = {20'(dout0), det0, sync0};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s lane10 data=%h det=%b sync=%b expected data=%h det=%b sync=%b",
                             t, a[21:2], a[1], a[0], e[21:2], e[1], e[0]);
                end
            end
            if (q1.size() > 0) begin
                e = q1.pop_front(); t = t1q.pop_front();
                a = {20'(dout1), det1, sync1};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s lane8 data=%h det=%b sync=%b expected data=%h det=%b sync=%b",
                             t, a[21:2], a[1], a[0], e[21:2], e[1], e[0]);
                end
            end
        end
    end

    task automatic reset_check(input string nm, input logic [20:0] act);
        checks++;
        if (act !== '0) begin
            errors++;
            $display("FAIL R10 %s after reset actual=%h expected=0", nm, act);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mw[0] = W0; mw[1] = W1; mlvl[0] = 1; mlvl[1] = 0;
        mpat[0] = 20'(P0); mpat[1] = 20'(P1);
        for (int i = 0; i < 2; i++) begin
            mcur[i] = '0; mprev[i] = '0; mst[i] = 0; mbnd[i] = 0; mpaq[i] = 0;
        end
        repeat (3) @(negedge clk);
        reset_check("lane10", {11'(dout0), det0, sync0});   // R10
        reset_check("lane8",  {13'(dout1), det1, sync1});   // R10

        // Lane 10: level-sensitive control
        tag0 = "R10 R1";
        for (int i = 0; i < 6; i++) s0(20'($urandom()));
        tag0 = "R7";
        pat0(3); s0(0); s0(0);
        tag0 = "R2 R4";
        hold0 = 1; s0(0); pat0(3); s0(0); s0(0);
        tag0 = "R5";
        pat0(3); s0(0);
        tag0 = "R1";
        for (int i = 0; i < 5; i++) s0(20'($urandom()));
        s0(0); s0(0);
        tag0 = "R6";
        pat0(7); s0(0); s0(0);
        pat0(1); s0(0); s0(0);
        pat0(7); s0(0); s0(0);
        tag0 = "R2 R7";
        hold0 = 0; s0(0); pat0(2); s0(0); s0(0);
        tag0 = "R9";
        pat0(7); s0(0); s0(0);

        // Lane 8: edge-armed control
        tag1 = "R3 R4";
        hold1 = 1; s1(0); s1(0); s1(0); pat1(5); s1(0); s1(0);
        tag1 = "R3";
        pat1(1); s1(0); s1(0);
        tag1 = "R5";
        pat1(5); s1(0); s1(0);
        tag1 = "R3 R4";
        hold1 = 0; s1(0); hold1 = 1; pat1(2); s1(0); s1(0);
        tag1 = "R8";
        hold1 = 0; s1(0); hold1 = 1; s1(0);
        s1(20'(P1)); s1(20'(P1)); s1(0); s1(0);
        hold1 = 0;
        s1(20'(P1)); s1(20'(P1)); s1(0); s1(0);
        tag1 = "R1";
        for (int i = 0; i < 5; i++) s1(20'($urandom()));

        s0(0); s0(0);
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule